// File: doc/BRIEF.md
# Tournament Direction Predictor (Global and Per-Branch History)

This block guesses whether a conditional branch will be taken. It holds two component predictors. The global component keeps one history register that every resolved branch shifts, and it indexes a table of shared 2-bit counters with that history XOR the branch's word-address bits. The per-branch component keeps a table of private histories, selected by the branch's word-address bits. It indexes a second shared counter table with the selected history XOR the same bits. Different branches may land on the same counter.

A third table of 2-bit chooser counters, indexed by the branch's word-address bits, picks which component answers each branch. The fetch side presents a PC on the prediction port and gets a combinational taken or not-taken answer in the same cycle. It also gets a flag that says which component supplied the answer. The resolve side presents the PC and the real outcome of each branch on the update port. That update trains every table on the next clock edge.

The address bits used everywhere are PC[IDX_W+1:2]. With the default IDX_W of 8 these are PC[9:2]. History length equals IDX_W.

Top module: `tourney_bp`

## Requirements
- R1: After reset every counter in both component tables holds 01 (weak not-taken), every history is zero, and every chooser counter holds 01. Every PC therefore predicts not-taken with the per-branch component selected.
- R2: Every counter is a 2-bit saturating counter: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. Bit 1 is the predicted direction (1 = taken). A taken update increments the counter and stops at 11. A not-taken update decrements it and stops at 00.
- R3: On each valid update the global history shifts left by one and takes the outcome (1 = taken) into bit 0. The global counter used is the one at global history XOR PC[9:2].
- R4: The per-branch history is selected by PC[9:2] and shifts the same way on an update to that entry. The per-branch counter used is the one at that history XOR PC[9:2].
- R5: The chooser counter at PC[9:2] picks the prediction. Bit 1 = 1 selects the global component and bit 1 = 0 selects the per-branch component. The predSelGlobal output shows that bit.
- R6: Every valid update trains both component counters and both histories, whichever component was selected.
- R7: The chooser counter changes only when exactly one component predicted the outcome correctly. It increments when the global component was right and decrements when the per-branch component was right. Both components are judged with the histories in effect at update time.
- R8: A prediction and an update in the same cycle, even for the same PC, give the prediction from the state before that update.
- R9: While updValid is low, no table and no history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predPc | input | PC_W | PC of the branch being fetched |
| predTaken | output | 1 | Predicted direction for predPc (1 = taken) |
| predSelGlobal | output | 1 | 1 when the global component supplied predTaken |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | PC of the resolved branch |
| updTaken | input | 1 | Real outcome of the resolved branch (1 = taken) |

## Verification
The hardest case to reach is a chooser counter that crosses to the global side. This needs one PC to meet repeated updates where the global component is right and the per-branch component is wrong, with both histories in changing states and counters shared between PCs. The stimulus draws branches from a small pool of PCs. Each PC has its own outcome rule: fixed, alternating, periodic, or copying the previous outcome of another branch. Correlated behaviour therefore builds up in the global history while the per-branch histories keep their own patterns. Directed runs then cover the reset state, saturation, an idle update port and a same-cycle read and write of one entry.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'b01;

  // strobes from control to datapath for one resolved branch
  typedef struct packed {
    logic trainGlob;
    logic trainLoc;
    logic metaInc;
    logic metaDec;
    logic outcome;
  } tbpStrobe_t;

  function automatic ctr2_t satStep(input ctr2_t c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

endpackage

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
  import tbp_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       gPredUpd,
  input  logic       lPredUpd,
  output tbpStrobe_t strb
);

  logic gRight;
  logic lRight;

  always_comb begin
    gRight         = (gPredUpd == updTaken);
    lRight         = (lPredUpd == updTaken);
    strb.trainGlob = updValid;
    strb.trainLoc  = updValid;
    strb.metaInc   = updValid && gRight && !lRight;
    strb.metaDec   = updValid && lRight && !gRight;
    strb.outcome   = updTaken;
  end

endmodule

// File: rtl/tbp_data.sv
module tbp_data
  import tbp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  predPc,
  input  logic [PC_W-1:0]  updPc,
  input  tbpStrobe_t       strb,
  output logic             predTaken,
  output logic             predSelGlobal,
  output logic             gPredUpd,
  output logic             lPredUpd,
  output logic [IDX_W-1:0] gHistOut
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int LO      = 2;
  localparam int HI      = IDX_W + 1;

  ctr2_t            gCtr  [ENTRIES];
  ctr2_t            lCtr  [ENTRIES];
  ctr2_t            meta  [ENTRIES];
  logic [IDX_W-1:0] lHist [ENTRIES];
  logic [IDX_W-1:0] gHist;

  logic [IDX_W-1:0] pIdx, pgIdx, plIdx;
  logic [IDX_W-1:0] uIdx, ugIdx, ulIdx;
  logic             unusedPcBits;

  assign unusedPcBits = ^{predPc[PC_W-1:HI+1], predPc[LO-1:0],
                          updPc[PC_W-1:HI+1], updPc[LO-1:0]};

  // prediction read: combinational, sees state before any same-cycle write
  always_comb begin
    pIdx          = predPc[HI:LO];
    pgIdx         = gHist ^ pIdx;
    plIdx         = lHist[pIdx] ^ pIdx;
    predSelGlobal = meta[pIdx][1];
    predTaken     = predSelGlobal ? gCtr[pgIdx][1] : lCtr[plIdx][1];
  end

  // update read: what each component would predict for the resolved branch
  always_comb begin
    uIdx     = updPc[HI:LO];
    ugIdx    = gHist ^ uIdx;
    ulIdx    = lHist[uIdx] ^ uIdx;
    gPredUpd = gCtr[ugIdx][1];
    lPredUpd = lCtr[ulIdx][1];
  end

  assign gHistOut = gHist;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gHist <= '0;
      for (int i = 0; i < ENTRIES; i++) gCtr[i] <= CTR_WEAK_NT;
    end else if (strb.trainGlob) begin
      gHist        <= {gHist[IDX_W-2:0], strb.outcome};
      gCtr[ugIdx]  <= satStep(gCtr[ugIdx], strb.outcome);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        lCtr[i]  <= CTR_WEAK_NT;
        lHist[i] <= '0;
      end
    end else if (strb.trainLoc) begin
      lCtr[ulIdx] <= satStep(lCtr[ulIdx], strb.outcome);
      lHist[uIdx] <= {lHist[uIdx][IDX_W-2:0], strb.outcome};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) meta[i] <= CTR_WEAK_NT;
    end else if (strb.metaInc) begin
      meta[uIdx] <= satStep(meta[uIdx], 1'b1);
    end else if (strb.metaDec) begin
      meta[uIdx] <= satStep(meta[uIdx], 1'b0);
    end
  end

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  output logic            predSelGlobal,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  tbpStrobe_t       strb;
  logic             gPredUpd;
  logic             lPredUpd;
  logic [IDX_W-1:0] gHist;

  tbp_ctrl u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .gPredUpd (gPredUpd),
    .lPredUpd (lPredUpd),
    .strb     (strb)
  );

  tbp_data #(.PC_W(PC_W), .IDX_W(IDX_W)) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .predPc        (predPc),
    .updPc         (updPc),
    .strb          (strb),
    .predTaken     (predTaken),
    .predSelGlobal (predSelGlobal),
    .gPredUpd      (gPredUpd),
    .lPredUpd      (lPredUpd),
    .gHistOut      (gHist)
  );

endmodule

// File: rtl/tbp_chk.sv
module tbp_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             updValid,
  input logic             updTaken,
  input logic             predTaken,
  input logic [IDX_W-1:0] gHist,
  input logic             trainGlob,
  input logic             trainLoc,
  input logic             metaInc,
  input logic             metaDec
);

  AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !predTaken); // R1

  AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> gHist == {$past(gHist[IDX_W-2:0]), $past(updTaken)}); // R3

  AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(gHist)); // R9

  AST_BOTH_TRAIN: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> (trainGlob && trainLoc)); // R6

  AST_META_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({metaInc, metaDec})); // R7

  AST_IDLE_NO_TRAIN: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !(trainGlob || trainLoc || metaInc || metaDec)); // R9

endmodule

bind tourney_bp tbp_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .updValid  (updValid),
  .updTaken  (updTaken),
  .predTaken (predTaken),
  .gHist     (gHist),
  .trainGlob (strb.trainGlob),
  .trainLoc  (strb.trainLoc),
  .metaInc   (strb.metaInc),
  .metaDec   (strb.metaDec)
);

// File: tb/test_tourney_bp.sv
module test_tourney_bp;

  localparam int PC_W    = 32;
  localparam int IDX_W   = 8;
  localparam int ENTRIES = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rstN;
  logic [PC_W-1:0] predPc;
  logic            predTaken;
  logic            predSelGlobal;
  logic            updValid;
  logic [PC_W-1:0] updPc;
  logic            updTaken;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .IDX_W(IDX_W)) i_tourney_bp (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .predSelGlobal(predSelGlobal), .updValid(updValid), .updPc(updPc),
    .updTaken(updTaken)
  );

  // reference state, built from the requirements
  logic [1:0]       mG [ENTRIES];
  logic [1:0]       mL [ENTRIES];
  logic [1:0]       mM [ENTRIES];
  logic [IDX_W-1:0] mLh [ENTRIES];
  logic [IDX_W-1:0] mGh;

  function automatic logic [IDX_W-1:0] ix(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? 2'b11 : c + 2'b01;
    return (c == 2'b00) ? 2'b00 : c - 2'b01;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < ENTRIES; i++) begin
      mG[i] = 2'b01; mL[i] = 2'b01; mM[i] = 2'b01; mLh[i] = '0;
    end
    mGh = '0;
  endtask

  task automatic modelPredict(input logic [PC_W-1:0] pc, output logic sel, output logic tk);
    logic [IDX_W-1:0] a;
    a   = ix(pc);
    sel = mM[a][1];
    tk  = sel ? mG[mGh ^ a][1] : mL[mLh[a] ^ a][1];
  endtask

  task automatic modelUpdate(input logic [PC_W-1:0] pc, input logic t);
    logic [IDX_W-1:0] a, gi, li;
    logic gOk, lOk;
    a   = ix(pc);
    gi  = mGh ^ a;
    li  = mLh[a] ^ a;
    gOk = (mG[gi][1] == t);
    lOk = (mL[li][1] == t);
    mG[gi] = sat(mG[gi], t);
    mL[li] = sat(mL[li], t);
    if (gOk && !lOk) mM[a] = sat(mM[a], 1'b1);
    if (lOk && !gOk) mM[a] = sat(mM[a], 1'b0);
    mGh    = {mGh[IDX_W-2:0], t};
    mLh[a] = {mLh[a][IDX_W-2:0], t};
  endtask

  task automatic check(input string tag, input logic actSel, input logic actTk,
                       input logic expSel, input logic expTk);
    checks++;
    if (actSel !== expSel || actTk !== expTk) begin
      errors++;
      $display("FAIL %s: pc=%h sel/taken actual %b%b expected %b%b",
               tag, predPc, actSel, actTk, expSel, expTk);
    end
  endtask

  // one cycle: drive, compare the same-cycle prediction against the model, advance
  task automatic step(input string tag, input logic [PC_W-1:0] pPc, input logic uv,
                      input logic [PC_W-1:0] uPc, input logic ut);
    logic eSel, eTk;
    @(negedge clk);
    predPc = pPc; updValid = uv; updPc = uPc; updTaken = ut;
    #1;
    modelPredict(pPc, eSel, eTk);
    check(tag, predSelGlobal, predTaken, eSel, eTk);
    if (uv) modelUpdate(uPc, ut);
  endtask

  // fixed-seed random stream over a small PC pool with per-PC outcome rules
  logic [PC_W-1:0] pool [8];
  logic            lastOut [8];

  initial begin
    logic [PC_W-1:0] p;
    logic            t;
    int              seed;
    seed = $urandom(32'd20240611);
    rstN = 1'b0; predPc = '0; updValid = 1'b0; updPc = '0; updTaken = 1'b0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state, not taken and per-branch component selected
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      predPc = $urandom(); updValid = 1'b0;
      #1;
      check("R1", predSelGlobal, predTaken, 1'b0, 1'b0);
    end

    // R9: update port idle while its data toggles; nothing may change
    for (int k = 0; k < 20; k++)
      step("R9", 32'h0000_0040, 1'b0, 32'h0000_0040 + 4 * k, 1'b1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      predPc = 32'h0000_0040 + 4 * k; updValid = 1'b0;
      #1;
      check("R9", predSelGlobal, predTaken, 1'b0, 1'b0);
    end

    // R2: one PC always taken; counters saturate at 11 and stay there
    for (int k = 0; k < 20; k++)
      step("R2", 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1);
    @(negedge clk);
    predPc = 32'h0000_0100; updValid = 1'b0;
    #1;
    check("R2", predSelGlobal, predTaken, 1'b0, 1'b1);
    step("R2", 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b0);
    step("R2", 32'h0000_0100, 1'b0, 32'h0000_0100, 1'b0);

    // R8: prediction and update to one entry in the same cycle
    for (int k = 0; k < 12; k++)
      step("R8", 32'h0000_0200, 1'b1, 32'h0000_0200, k[0]);

    // R4: two PCs with opposite fixed patterns keep separate histories
    for (int k = 0; k < 24; k++) begin
      step("R4", 32'h0000_0300, 1'b1, 32'h0000_0300, 1'b1);
      step("R4", 32'h0000_0304, 1'b1, 32'h0000_0304, 1'b0);
    end

    // R3 R5 R6 R7: random mix with correlated branches
    for (int k = 0; k < 8; k++) begin
      pool[k] = {$urandom()} & 32'h0000_03fc;
      lastOut[k] = 1'b0;
    end
    for (int n = 0; n < 6000; n++) begin
      int s;
      s = $urandom_range(7);
      p = pool[s];
      case (s)
        0:       t = 1'b1;
        1:       t = 1'b0;
        2:       t = ~lastOut[2];
        3:       t = (n % 3) == 0;
        4:       t = lastOut[0] ^ lastOut[2];
        5:       t = ~lastOut[4];
        default: t = $urandom_range(1);
      endcase
      lastOut[s] = t;
      step("R3 R5 R6 R7", pool[$urandom_range(7)], ($urandom_range(9) != 0), p, t);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule